// File: doc/BRIEF.md
# Dual-Bank Latch/Register Bus Driver

This block drives two independent 18-bit data buses. Each bank has its own data input, data output, active-low drive enable, pass-through control and bank clock. Every bit of a bank can work in one of three ways:

- pass input data straight to the output;
- hold a stored value;
- load new data on a rising edge of the bank clock.

The output stage of each bank has two parts. The first is a data bus. The second is a drive-enable flag that an outer pad ring or tri-state wrapper uses to release the line. Because of this split, the core contains no internal tri-state nets.

The bank clock and the pass-through control are treated as level inputs. They are sampled on the system clock `clk`, and a bank-clock rise is detected by comparing two successive samples. The pass-through path from data input to data output is purely combinational. The stored value changes only on `clk` edges.

Each bank runs a three-state controller:

- **FOLLOW**: pass-through is on.
- **WAIT_RISE**: the bank is holding and its clock was sampled low.
- **CLK_HIGH**: the bank is holding and its clock was sampled high.

The controller has these transitions:

- *OPEN*: any state goes to FOLLOW while pass-through is high.
- *CLOSE_LOW*: FOLLOW goes to WAIT_RISE when pass-through drops while the bank clock is low.
- *CLOSE_HIGH*: FOLLOW goes to CLK_HIGH when pass-through drops while the bank clock is high.
- *CAPTURE*: WAIT_RISE goes to CLK_HIGH when a bank-clock rise loads the data.
- *FALL*: CLK_HIGH goes to WAIT_RISE when the bank clock returns low.

Reset places each controller in CLK_HIGH.

Top module: `bdrv_dual`

## Requirements
- R1: Synchronous reset `rst` clears the stored value of every bank to 0 and puts each controller in CLK_HIGH. As a result, a bank clock that is already high at the first edges after reset does not load data; a load needs a low sample first.
- R2: `q_en[b]` is 1 exactly when `oe_n[b]` is 0. It is independent of pass-through, bank clock, data and reset.
- R3: While `pass[b]` is 1, bank b's output slice equals its input slice in the same cycle, whatever the bank clock does.
- R4: With `pass[b]` at 0, when `bclk[b]` is sampled 0 at one `clk` edge and 1 at the next, the input slice present at that later edge is stored. It appears on the output after that edge. This also applies when pass-through drops in the same cycle that the bank clock rises.
- R5: With `pass[b]` at 0 and the bank clock not rising, the output keeps its stored value while the data inputs change.
- R6: When `pass[b]` drops while the bank clock is high, the held value is the input slice sampled at the last `clk` edge at which `pass[b]` was still 1.
- R7: Toggling `oe_n[b]` never changes the stored value. After the bank is re-enabled, the output shows the value held before it was disabled.
- R8: A bank-clock rise that occurs while `pass[b]` is 1 leaves nothing behind. After pass-through drops with the clock held high, the output holds the last followed input.
- R9: Activity on one bank's inputs never changes the other bank's outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all storage and control sampling |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 36 | Data inputs; bank b uses bits [18b+17:18b] |
| oe_n | input | 2 | Per-bank drive enable, active low |
| pass | input | 2 | Per-bank pass-through control |
| bclk | input | 2 | Per-bank load clock, sampled as a level |
| q | output | 36 | Data outputs; bank b on bits [18b+17:18b] |
| q_en | output | 2 | Per-bank drive-enable for the output stage |

## Verification
Two bank functions can fall in the same `clk` cycle: closing the pass-through path and detecting a bank-clock rise. If both happen in one cycle, the new input must be loaded rather than the last followed value.

The bench drives this collision in two ways. Directed steps lower `pass` and raise `bclk` together while changing `din`. Random stimulus also toggles both controls independently. A bench model of the stored value and the previous clock sample predicts the result, and the output is compared one cycle after the edge to decide which value won.

// File: rtl/bdrv_pkg.sv
package bdrv_pkg;
    typedef enum logic [1:0] {
        ST_FOLLOW    = 2'd0,
        ST_WAIT_RISE = 2'd1,
        ST_CLK_HIGH  = 2'd2
    } bank_mode_e;
endpackage

// File: rtl/bdrv_mode_fsm.sv
module bdrv_mode_fsm
    import bdrv_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pass_i,
    input  logic       bclk_i,
    output bank_mode_e state_o,
    output logic       load_o
);
    bank_mode_e state_q;
    bank_mode_e state_d;
    logic       clk_seen_q;

    // State register; clk_seen_q remembers the last bank-clock sample.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_CLK_HIGH;
            clk_seen_q <= 1'b1;
        end else begin
            state_q    <= state_d;
            clk_seen_q <= bclk_i;
        end
    end

    // Transitions: OPEN, CLOSE_LOW, CLOSE_HIGH, CAPTURE, FALL.
    always_comb begin
        state_d = state_q;
        if (pass_i) begin
            state_d = ST_FOLLOW;
        end else begin
            unique case (state_q)
                ST_FOLLOW:    state_d = bclk_i ? ST_CLK_HIGH : ST_WAIT_RISE;
                ST_WAIT_RISE: state_d = bclk_i ? ST_CLK_HIGH : ST_WAIT_RISE;
                ST_CLK_HIGH:  state_d = bclk_i ? ST_CLK_HIGH : ST_WAIT_RISE;
                default:      state_d = ST_CLK_HIGH;
            endcase
        end
    end

    // Load strobe: follow while open, or take the input on a detected rise.
    always_comb begin
        load_o = 1'b0;
        unique case (state_q)
            ST_FOLLOW:    load_o = pass_i | (bclk_i & ~clk_seen_q);
            ST_WAIT_RISE: load_o = pass_i | bclk_i;
            ST_CLK_HIGH:  load_o = pass_i;
            default:      load_o = 1'b0;
        endcase
    end

    assign state_o = state_q;

    // R4
    wait_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT_RISE && !pass_i && bclk_i) |=> (state_q == ST_CLK_HIGH));

    // R3
    open_state_chk: assert property (@(posedge clk) disable iff (rst)
        pass_i |=> (state_q == ST_FOLLOW));
endmodule

// File: rtl/bdrv_store.sv
module bdrv_store #(
    parameter int WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
        end else if (load_i) begin
            held_q <= d_i;
        end
    end

    assign q_o = held_q;

    // R1
    clear_after_rst_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (held_q == '0));
endmodule

// File: rtl/bdrv_bank.sv
module bdrv_bank
    import bdrv_pkg::*;
#(
    parameter int WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din_i,
    input  logic             oe_n_i,
    input  logic             pass_i,
    input  logic             bclk_i,
    output logic [WIDTH-1:0] q_o,
    output logic             q_en_o
);
    bank_mode_e       mode;
    logic             load;
    logic [WIDTH-1:0] held;

    bdrv_mode_fsm i_fsm (
        .clk     (clk),
        .rst     (rst),
        .pass_i  (pass_i),
        .bclk_i  (bclk_i),
        .state_o (mode),
        .load_o  (load)
    );

    bdrv_store #(.WIDTH(WIDTH)) i_store (
        .clk    (clk),
        .rst    (rst),
        .load_i (load),
        .d_i    (din_i),
        .q_o    (held)
    );

    // Output stage: data path plus drive flag, no internal tri-state.
    always_comb begin
        q_o    = pass_i ? din_i : held;
        q_en_o = ~oe_n_i;
    end

    // R3
    follow_store_chk: assert property (@(posedge clk) disable iff (rst)
        pass_i |=> (held == $past(din_i)));

    // R5
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!pass_i && $stable(bclk_i)) |=> $stable(held));

    // R7
    oe_no_touch_chk: assert property (@(posedge clk) disable iff (rst)
        (!pass_i && !bclk_i && $rose(oe_n_i)) |=> $stable(held));

    // R8
    close_high_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == ST_FOLLOW && !pass_i && bclk_i && $past(bclk_i)) |=> $stable(held));
endmodule

// File: rtl/bdrv_dual.sv
module bdrv_dual #(
    parameter int NUM_BANKS = 2,
    parameter int BANK_W    = 18
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_BANKS*BANK_W-1:0] din,
    input  logic [NUM_BANKS-1:0]        oe_n,
    input  logic [NUM_BANKS-1:0]        pass,
    input  logic [NUM_BANKS-1:0]        bclk,
    output logic [NUM_BANKS*BANK_W-1:0] q,
    output logic [NUM_BANKS-1:0]        q_en
);
    localparam int BUS_W = NUM_BANKS * BANK_W;

    logic [BUS_W-1:0] q_bus;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        bdrv_bank #(.WIDTH(BANK_W)) i_bank (
            .clk    (clk),
            .rst    (rst),
            .din_i  (din[b*BANK_W +: BANK_W]),
            .oe_n_i (oe_n[b]),
            .pass_i (pass[b]),
            .bclk_i (bclk[b]),
            .q_o    (q_bus[b*BANK_W +: BANK_W]),
            .q_en_o (q_en[b])
        );

        // R2
        drive_off_chk: assert property (@(posedge clk) disable iff (rst)
            oe_n[b] |-> !q_en[b]);
    end

    assign q = q_bus;
endmodule

// File: tb/test_bdrv_dual.sv
module test_bdrv_dual;
    localparam int NB = 2;
    localparam int W  = 18;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NB*W-1:0] din = '0;
    logic [NB-1:0]   oe_n = '1;
    logic [NB-1:0]   pass = '0;
    logic [NB-1:0]   bclk = '1;
    logic [NB*W-1:0] q;
    logic [NB-1:0]   q_en;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [W-1:0] m_st [NB];
    logic         m_ck [NB];
    bit           m_cap[NB];
    string        tag_ovr = "";
    bit           do_chk  = 0;

    always #2 clk = ~clk;

    bdrv_dual i_bdrv_dual (
        .clk (clk), .rst (rst), .din (din), .oe_n (oe_n),
        .pass (pass), .bclk (bclk), .q (q), .q_en (q_en)
    );

    function automatic logic [W-1:0] exp_q(int b);
        return pass[b] ? din[b*W +: W] : m_st[b];
    endfunction

    task automatic check(string tag, logic [W-1:0] got, logic [W-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic set_bank(int b, logic oe, logic ps, logic ck, logic [W-1:0] d);
        oe_n[b] = oe;
        pass[b] = ps;
        bclk[b] = ck;
        din[b*W +: W] = d;
    endtask

    // Inputs are set after a falling edge; compare, then advance one clk.
    task automatic step();
        #1;
        if (do_chk) begin
            for (int b = 0; b < NB; b++) begin
                string t;
                check("R2", {17'd0, q_en[b]}, {17'd0, ~oe_n[b]});
                if (tag_ovr != "") t = tag_ovr;
                else if (pass[b]) t = "R3";
                else if (m_cap[b]) t = "R4";
                else t = "R5";
                check(t, q[b*W +: W], exp_q(b));
            end
        end
        @(posedge clk);
        for (int b = 0; b < NB; b++) begin
            m_cap[b] = 0;
            if (rst) begin
                m_st[b] = '0;
                m_ck[b] = 1'b1;
            end else begin
                if (pass[b]) m_st[b] = din[b*W +: W];
                else if (bclk[b] && !m_ck[b]) begin
                    m_st[b] = din[b*W +: W];
                    m_cap[b] = 1;
                end
                m_ck[b] = bclk[b];
            end
        end
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got hang expected completion");
        finish_run();
    end

    initial begin
        logic [W-1:0] va, vb, vc, hold1;
        void'($urandom(32'h1c3a));
        for (int b = 0; b < NB; b++) begin
            m_st[b] = '0;
            m_ck[b] = 1'b1;
            m_cap[b] = 0;
        end
        @(negedge clk);
        step();
        step();
        rst = 1'b0;
        do_chk = 1;

        // R1: cleared store; a clock already high does not load.
        tag_ovr = "R1";
        set_bank(0, 1'b0, 1'b0, 1'b1, 18'h2a5a5);
        set_bank(1, 1'b0, 1'b0, 1'b1, 18'h15a5a);
        step();
        step();
        check("R1", q[0 +: W], 18'h0);

        // R3: follow while clock toggles.
        tag_ovr = "R3";
        for (int i = 0; i < 4; i++) begin
            set_bank(0, 1'b0, 1'b1, 1'(i), 18'($urandom));
            step();
        end

        // R6: close while clock high; hold last followed value.
        va = 18'h11111;
        vb = 18'h22222;
        set_bank(0, 1'b0, 1'b1, 1'b1, va);
        step();
        tag_ovr = "R6";
        set_bank(0, 1'b0, 1'b0, 1'b1, vb);
        step();
        set_bank(0, 1'b0, 1'b0, 1'b1, 18'h3c3c3);
        step();
        check("R6", q[0 +: W], va);

        // R4: low sample then rise loads.
        tag_ovr = "R4";
        set_bank(0, 1'b0, 1'b0, 1'b0, 18'h00f0f);
        step();
        vc = 18'h2bead;
        set_bank(0, 1'b0, 1'b0, 1'b1, vc);
        step();
        set_bank(0, 1'b0, 1'b0, 1'b1, 18'h0aaaa);
        step();
        check("R4", q[0 +: W], vc);

        // R4: pass drops in the same cycle the clock rises.
        set_bank(0, 1'b0, 1'b1, 1'b0, 18'h01234);
        step();
        set_bank(0, 1'b0, 1'b0, 1'b1, 18'h05678);
        step();
        check("R4", q[0 +: W], 18'h05678);

        // R7: disable, disturb data, re-enable; stored value kept.
        tag_ovr = "R7";
        hold1 = 18'h05678;
        set_bank(0, 1'b1, 1'b0, 1'b1, 18'h3ffff);
        step();
        set_bank(0, 1'b1, 1'b0, 1'b1, 18'h00001);
        step();
        set_bank(0, 1'b0, 1'b0, 1'b1, 18'h00002);
        step();
        check("R7", q[0 +: W], hold1);

        // R8: clock rise while open leaves nothing behind.
        tag_ovr = "R8";
        set_bank(0, 1'b0, 1'b1, 1'b0, 18'h0dddd);
        step();
        set_bank(0, 1'b0, 1'b1, 1'b1, 18'h0eeee);
        step();
        set_bank(0, 1'b0, 1'b1, 1'b1, 18'h1f00f);
        step();
        set_bank(0, 1'b0, 1'b0, 1'b1, 18'h00300);
        step();
        check("R8", q[0 +: W], 18'h1f00f);

        // R9: bank 1 busy, bank 0 held.
        tag_ovr = "R9";
        for (int i = 0; i < 12; i++) begin
            set_bank(1, 1'($urandom), 1'($urandom), 1'($urandom), 18'($urandom));
            step();
            check("R9", q[0 +: W], 18'h1f00f);
        end

        // Random mix across both banks.
        tag_ovr = "";
        for (int i = 0; i < 3000; i++) begin
            for (int b = 0; b < NB; b++) begin
                logic ps;
                ps = ($urandom % 4) == 0;
                set_bank(b, 1'(($urandom % 5) == 0), ps, 1'($urandom), 18'($urandom));
            end
            step();
        end

        finish_run();
    end
endmodule